// File: doc/BRIEF.md
# Cartridge Bank Mapper with Scheme Auto-Detection

This block sits between a CPU with a 64 KB address space and an external cartridge ROM. It watches every CPU write and keeps a set of bank registers. For the address currently on the bus, it produces a ROM byte address, or a cartridge-RAM select with a bank bit, or a work-RAM select. The ROM, the cartridge RAM and the work RAM are all outside the block. Address decoding is combinational from the CPU address and the registered state, so a lookup costs no cycle. A register write takes effect from the clock edge that samples it.

Three banking schemes are supported:
- **Slot-16K**: three 16 KB slots, programmed through the top four bytes of the address space, with optional battery RAM in the third slot.
- **Window-8K**: four 8 KB windows, programmed at the bottom four addresses.
- **Base-16K**: three 16 KB slots, programmed by writing at each slot's own base address.

The scheme in use is not configured. The first write that qualifies for a scheme selects it, and that choice holds until reset. ROM size is set by a parameter, and every bank number is reduced to the bits that the ROM size allows.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the scheme code is 0 (none), and 0x0000–0xBFFF map linearly to ROM offsets 0x0000–0xBFFF.
- R2: With scheme 0, a write is tested against three candidates in this priority order. Any write to 0xFFF8–0xFFFF with nonzero data selects scheme 1 (slot-16K). Otherwise, a write to 0x0000–0x0003 selects scheme 2 (window-8K) unless both address and data are zero. Otherwise, a write to 0x0000, 0x4000, 0x8000 or 0xA000 selects scheme 3 (base-16K) unless both address and data are zero. The selecting write is also applied as a register write of that scheme.
- R3: Once the scheme code is nonzero it never changes until reset, and writes aimed at another scheme's registers have no effect on the mapping.
- R4: In scheme 1 (and before detection), writes to 0xFFFD, 0xFFFE and 0xFFFF set the banks of windows 0x0000, 0x4000 and 0x8000, while 0x0000–0x03FF always map to ROM offset 0x0000–0x03FF.
- R5: In scheme 1, a write to 0xFFFC with bit 3 set replaces ROM at 0x8000–0xBFFF with cartridge RAM (cram_sel high), and bit 2 of that write gives cram_bank.
- R6: In scheme 1, a control write to 0xFFFC with any bit outside 0x8C set drives ctl_anomaly high for exactly the cycle after the write.
- R7: 16 KB bank numbers keep their low ROM_AW−14 bits, and 8 KB bank numbers keep their low ROM_AW−13 bits.
- R8: In scheme 2, writes to 0x0000, 0x0001, 0x0002 and 0x0003 set the banks of 8 KB windows 0x8000, 0xA000, 0x4000 and 0x6000, whose reset banks are 4, 5, 2 and 3. Addresses 0x0000–0x3FFF stay linear.
- R9: In scheme 3, a write to 0x0000, 0x4000 or 0x8000 sets the bank of the 16 KB window at that base, and 0xA000 acts as 0x8000. There is no fixed first 1 KB.
- R10: Addresses 0xC000–0xFFFF select work RAM at wram_addr = address bits 12:0, so 0xE000–0xFFFF mirrors 0xC000–0xDFFF. A write there raises wram_we in the same cycle.
- R11: Exactly one of rom_sel, cram_sel and wram_sel is high at any time, and rom_addr is zero whenever rom_sel is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| rom_addr | output | ROM_AW | ROM byte address for cpu_addr |
| rom_sel | output | 1 | Access goes to ROM |
| cram_sel | output | 1 | Access goes to cartridge RAM |
| cram_bank | output | 1 | Cartridge RAM 16 KB bank |
| wram_sel | output | 1 | Access goes to work RAM |
| wram_we | output | 1 | Work RAM write strobe |
| wram_addr | output | 13 | Work RAM byte address |
| scheme | output | 2 | Locked scheme: 0 none, 1 slot-16K, 2 window-8K, 3 base-16K |
| ctl_anomaly | output | 1 | Slot-16K control write had unexpected bits |

## Verification
The bench builds the mapper with ROM_AW = 17, a 128 KB ROM. That gives a 3-bit 16 KB bank and a 4-bit 8 KB bank, so bank values such as 9 and 0x1F show that the upper bits are discarded. Cartridge RAM stays enabled, so the RAM-in-slot path and its bank bit can be observed. The bench resets between schemes so that each scheme can be selected fresh. This covers zero-data writes that must not select a scheme, the priority of the window-8K scheme over base-16K at address 0, and writes that a locked scheme must ignore.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
   typedef enum logic [1:0] {
      SCH_NONE   = 2'd0,
      SCH_SLOT16 = 2'd1,
      SCH_WIN8   = 2'd2,
      SCH_BASE16 = 2'd3
   } scheme_e;

   localparam int unsigned PAGE16_BITS = 14;
   localparam int unsigned PAGE8_BITS  = 13;
   localparam int unsigned WRAM_AW     = 13;
   localparam logic [15:0] FIXED_TOP   = 16'h0400;
   // bits a slot-16K control write may legally carry
   localparam logic [7:0]  CTL_LEGAL   = 8'h8C;
endpackage

// File: rtl/cbm_detect.sv
module cbm_detect
   import cbm_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [15:0] addr,
   input  logic [7:0]  wdata,
   output scheme_e     scheme,
   output logic        acc_slot16,
   output logic        acc_win8,
   output logic        acc_base16
);
   scheme_e scheme_q, cand;
   logic    hit_s16, hit_w8, hit_b16, data_nz, any_nz;

   assign hit_s16 = (addr[15:3] == 13'h1FFF);
   assign hit_w8  = (addr[15:2] == 14'h0);
   assign hit_b16 = (addr[13:0] == 14'h0 && addr[15:14] != 2'b11) || (addr == 16'hA000);
   assign data_nz = |wdata;
   assign any_nz  = data_nz || (|addr);

   always_comb begin
      cand = scheme_q;
      if (wr && scheme_q == SCH_NONE) begin
         if (hit_s16 && data_nz)     cand = SCH_SLOT16;
         else if (hit_w8 && any_nz)  cand = SCH_WIN8;
         else if (hit_b16 && any_nz) cand = SCH_BASE16;
      end
   end

   assign acc_slot16 = wr && hit_s16 && cand == SCH_SLOT16;
   assign acc_win8   = wr && hit_w8  && cand == SCH_WIN8;
   assign acc_base16 = wr && hit_b16 && cand == SCH_BASE16;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scheme_q <= SCH_NONE;
      else        scheme_q <= cand;
   end

   assign scheme = scheme_q;

   // R3
   scheme_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scheme_q != SCH_NONE) |=> (scheme_q == $past(scheme_q)));

   // R2
   zero_no_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scheme_q == SCH_NONE && wr && wdata == 8'h00 && addr[15:3] == 13'h1FFF)
      |=> (scheme_q == SCH_NONE));
endmodule

// File: rtl/cbm_bank_regs.sv
module cbm_bank_regs
   import cbm_pkg::*;
#(
   parameter int unsigned BANK_W = 5
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   acc_slot16,
   input  logic                   acc_win8,
   input  logic                   acc_base16,
   input  logic [15:0]            addr,
   input  logic [7:0]             wdata,
   output logic [2:0][BANK_W-1:0] sg_bank,
   output logic                   ram_en,
   output logic                   ram_bank,
   output logic [3:0][BANK_W:0]   w8_bank,
   output logic [2:0][BANK_W-1:0] b16_bank,
   output logic                   anomaly
);
   localparam int unsigned W8_W = BANK_W + 1;

   logic       ctl_wr;
   logic [1:0] b16_idx;

   assign ctl_wr  = acc_slot16 && addr[2:0] == 3'd4;
   assign b16_idx = (addr == 16'hA000) ? 2'd2 : addr[15:14];

   // slot-16K bank registers at 0xFFFD..0xFFFF, and base-16K slots
   for (genvar s = 0; s < 3; s++) begin : g_slot
      logic [BANK_W-1:0] sg_q, b16_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sg_q  <= BANK_W'(s);
            b16_q <= BANK_W'(s);
         end else begin
            if (acc_slot16 && addr[2:0] == 3'(5 + s)) sg_q <= wdata[BANK_W-1:0];
            if (acc_base16 && b16_idx == 2'(s))       b16_q <= wdata[BANK_W-1:0];
         end
      end
      assign sg_bank[s]  = sg_q;
      assign b16_bank[s] = b16_q;
   end

   // window-8K registers at 0x0000..0x0003
   for (genvar w = 0; w < 4; w++) begin : g_win
      localparam int unsigned RST = (w < 2) ? w + 4 : w;
      logic [W8_W-1:0] w8_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             w8_q <= W8_W'(RST);
         else if (acc_win8 && addr[1:0] == 2'(w)) w8_q <= wdata[W8_W-1:0];
      end
      assign w8_bank[w] = w8_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ram_en   <= 1'b0;
         ram_bank <= 1'b0;
         anomaly  <= 1'b0;
      end else begin
         anomaly <= ctl_wr && |(wdata & ~CTL_LEGAL);
         if (ctl_wr) begin
            ram_en   <= wdata[3];
            ram_bank <= wdata[2];
         end
      end
   end

   // R6
   anomaly_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      anomaly |-> $past(acc_slot16 && addr == 16'hFFFC));
endmodule

// File: rtl/cbm_xlate.sv
module cbm_xlate
   import cbm_pkg::*;
#(
   parameter int unsigned ROM_AW       = 19,
   parameter int unsigned BANK_W       = 5,
   parameter bit          HAS_CART_RAM = 1'b1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [15:0]            addr,
   input  scheme_e                scheme,
   input  logic [2:0][BANK_W-1:0] sg_bank,
   input  logic                   ram_en,
   input  logic                   ram_bank,
   input  logic [3:0][BANK_W:0]   w8_bank,
   input  logic [2:0][BANK_W-1:0] b16_bank,
   output logic [ROM_AW-1:0]      rom_addr,
   output logic                   rom_sel,
   output logic                   cram_sel,
   output logic                   cram_bank,
   output logic                   wram_sel
);
   logic       ram_live;
   logic [1:0] slot, widx;

   if (HAS_CART_RAM) begin : g_cram
      assign ram_live = ram_en;
   end else begin : g_nocram
      assign ram_live = 1'b0;
   end

   assign slot = addr[15:14];
   // windows 0x4000/0x6000/0x8000/0xA000 use registers 2/3/0/1
   assign widx = 2'(addr[15:13] - 3'd2) ^ 2'b10;

   always_comb begin
      rom_addr  = '0;
      cram_sel  = 1'b0;
      cram_bank = 1'b0;
      wram_sel  = 1'b0;
      if (slot == 2'b11) begin
         wram_sel = 1'b1;
      end else begin
         unique case (scheme)
            SCH_WIN8: begin
               if (slot == 2'b00) rom_addr = ROM_AW'(addr[13:0]);
               else               rom_addr = {w8_bank[widx], addr[PAGE8_BITS-1:0]};
            end
            SCH_BASE16: begin
               case (slot)
                  2'd0:    rom_addr = {b16_bank[0], addr[PAGE16_BITS-1:0]};
                  2'd1:    rom_addr = {b16_bank[1], addr[PAGE16_BITS-1:0]};
                  default: rom_addr = {b16_bank[2], addr[PAGE16_BITS-1:0]};
               endcase
            end
            default: begin
               if (addr < FIXED_TOP) begin
                  rom_addr = ROM_AW'(addr[9:0]);
               end else if (slot == 2'd2 && ram_live) begin
                  cram_sel  = 1'b1;
                  cram_bank = ram_bank;
               end else begin
                  case (slot)
                     2'd0:    rom_addr = {sg_bank[0], addr[PAGE16_BITS-1:0]};
                     2'd1:    rom_addr = {sg_bank[1], addr[PAGE16_BITS-1:0]};
                     default: rom_addr = {sg_bank[2], addr[PAGE16_BITS-1:0]};
                  endcase
               end
            end
         endcase
      end
   end

   assign rom_sel = !wram_sel && !cram_sel;

   // R4
   lowkb_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((scheme == SCH_NONE || scheme == SCH_SLOT16) && addr < FIXED_TOP)
      |-> (rom_sel && rom_addr == ROM_AW'(addr)));

   // R11
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rom_sel, cram_sel, wram_sel}) == 1);

   // R5
   cram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cram_sel |-> (addr[15:14] == 2'b10 && scheme != SCH_WIN8 && scheme != SCH_BASE16));
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
   import cbm_pkg::*;
#(
   parameter int unsigned ROM_AW       = 19,
   parameter bit          HAS_CART_RAM = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic [15:0]       cpu_addr,
   input  logic [7:0]        cpu_wdata,
   output logic [ROM_AW-1:0] rom_addr,
   output logic              rom_sel,
   output logic              cram_sel,
   output logic              cram_bank,
   output logic              wram_sel,
   output logic              wram_we,
   output logic [12:0]       wram_addr,
   output logic [1:0]        scheme,
   output logic              ctl_anomaly
);
   localparam int unsigned BANK_W = ROM_AW - PAGE16_BITS;

   if (ROM_AW < 15 || ROM_AW > 21) begin : g_bad_rom_aw
      $error("cart_bank_mapper: ROM_AW must lie in 15..21");
   end

   scheme_e                 sch;
   logic                    acc_s16, acc_w8, acc_b16;
   logic [2:0][BANK_W-1:0]  sg_bank, b16_bank;
   logic [3:0][BANK_W:0]    w8_bank;
   logic                    ram_en, ram_bank;

   cbm_detect u_detect (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (cpu_wr),
      .addr       (cpu_addr),
      .wdata      (cpu_wdata),
      .scheme     (sch),
      .acc_slot16 (acc_s16),
      .acc_win8   (acc_w8),
      .acc_base16 (acc_b16)
   );

   cbm_bank_regs #(.BANK_W(BANK_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_slot16 (acc_s16),
      .acc_win8   (acc_w8),
      .acc_base16 (acc_b16),
      .addr       (cpu_addr),
      .wdata      (cpu_wdata),
      .sg_bank    (sg_bank),
      .ram_en     (ram_en),
      .ram_bank   (ram_bank),
      .w8_bank    (w8_bank),
      .b16_bank   (b16_bank),
      .anomaly    (ctl_anomaly)
   );

   cbm_xlate #(.ROM_AW(ROM_AW), .BANK_W(BANK_W), .HAS_CART_RAM(HAS_CART_RAM)) u_xlate (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (cpu_addr),
      .scheme    (sch),
      .sg_bank   (sg_bank),
      .ram_en    (ram_en),
      .ram_bank  (ram_bank),
      .w8_bank   (w8_bank),
      .b16_bank  (b16_bank),
      .rom_addr  (rom_addr),
      .rom_sel   (rom_sel),
      .cram_sel  (cram_sel),
      .cram_bank (cram_bank),
      .wram_sel  (wram_sel)
   );

   assign scheme    = sch;
   assign wram_we   = cpu_wr && cpu_addr[15:14] == 2'b11;
   assign wram_addr = cpu_addr[WRAM_AW-1:0];

   // R10
   wram_we_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wram_we |-> (wram_sel && !rom_sel));
endmodule

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
   localparam int CLK_NS = 10;
   localparam int ROM_AW = 17;
   localparam int M16    = (1 << (ROM_AW - 14)) - 1;
   localparam int M8     = 2 * M16 + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_wr = 1'b0;
   logic [15:0]       cpu_addr = 16'h0;
   logic [7:0]        cpu_wdata = 8'h0;
   logic [ROM_AW-1:0] rom_addr;
   logic              rom_sel, cram_sel, cram_bank, wram_sel, wram_we;
   logic [12:0]       wram_addr;
   logic [1:0]        scheme;
   logic              ctl_anomaly;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // behavioural reference state
   int m_type, m_ram_en, m_ram_bk, m_anom;
   int m_sg[3];
   int m_w8[4];
   int m_b16[3];

   cart_bank_mapper #(.ROM_AW(ROM_AW), .HAS_CART_RAM(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .rom_addr(rom_addr), .rom_sel(rom_sel),
      .cram_sel(cram_sel), .cram_bank(cram_bank), .wram_sel(wram_sel),
      .wram_we(wram_we), .wram_addr(wram_addr), .scheme(scheme),
      .ctl_anomaly(ctl_anomaly)
   );

   always #(CLK_NS/2) clk = ~clk;

   task automatic chk(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s at t=%0t addr=%h: got %h expected %h", req, $time, cpu_addr, got, exp);
      end
   endtask

   function automatic int exp_rom(int a);
      int slot;
      slot = a >> 14;
      if (a >= 'hC000) return 0;
      case (m_type)
         2: begin
            if (a < 'h4000) return a;
            return (m_w8[((a >> 13) - 2) ^ 2] & M8) * 8192 + (a & 'h1FFF);
         end
         3: return (m_b16[slot] & M16) * 16384 + (a & 'h3FFF);
         default: begin
            if (a < 'h400) return a;
            if (slot == 2 && m_ram_en != 0) return 0;
            return (m_sg[slot] & M16) * 16384 + (a & 'h3FFF);
         end
      endcase
   endfunction

   function automatic int exp_cram(int a);
      return (a >= 'h8000 && a < 'hC000 && m_type <= 1 && m_ram_en != 0) ? 1 : 0;
   endfunction

   // reference model advances on every clock edge
   always @(posedge clk) begin
      int a, d, t;
      bit hs, hm, hc;
      if (!rst_n) begin
         m_type = 0; m_ram_en = 0; m_ram_bk = 0; m_anom = 0;
         for (int i = 0; i < 3; i++) begin m_sg[i] = i; m_b16[i] = i; end
         m_w8[0] = 4; m_w8[1] = 5; m_w8[2] = 2; m_w8[3] = 3;
      end else begin
         m_anom = 0;
         if (cpu_wr) begin
            a = int'(cpu_addr); d = int'(cpu_wdata); t = m_type;
            hs = (a >= 'hFFF8);
            hm = (a <= 3);
            hc = (a == 0 || a == 'h4000 || a == 'h8000 || a == 'hA000);
            if (t == 0) begin
               if (hs && d != 0) t = 1;
               else if (hm && (a | d) != 0) t = 2;
               else if (hc && (a | d) != 0) t = 3;
            end
            m_type = t;
            if (t == 1 && hs) begin
               if (a == 'hFFFC) begin
                  m_ram_en = (d >> 3) & 1;
                  m_ram_bk = (d >> 2) & 1;
                  m_anom   = ((d & 'h73) != 0) ? 1 : 0;
               end else if (a >= 'hFFFD) begin
                  m_sg[a - 'hFFFD] = d;
               end
            end
            if (t == 2 && hm) m_w8[a] = d;
            if (t == 3 && hc) m_b16[(a == 'hA000) ? 2 : (a >> 14)] = d;
         end
      end
   end

   // every-clock comparison against the model
   always @(negedge clk) begin
      int a;
      #1;
      if (rst_n && !done) begin
         a = int'(cpu_addr);
         chk("R2 scheme", int'(scheme), m_type);
         chk("R7 rom_addr", int'(rom_addr), exp_rom(a));
         chk("R5 cram_sel", int'(cram_sel), exp_cram(a));
         if (exp_cram(a) != 0) chk("R5 cram_bank", int'(cram_bank), m_ram_bk);
         chk("R10 wram_sel", int'(wram_sel), (a >= 'hC000) ? 1 : 0);
         chk("R10 wram_we", int'(wram_we), (cpu_wr && a >= 'hC000) ? 1 : 0);
         chk("R10 wram_addr", int'(wram_addr), a & 'h1FFF);
         chk("R11 rom_sel", int'(rom_sel), (a < 'hC000 && exp_cram(a) == 0) ? 1 : 0);
         chk("R6 ctl_anomaly", int'(ctl_anomaly), m_anom);
      end
   end

   task automatic wr(int a, int d);
      @(negedge clk);
      cpu_wr = 1'b1; cpu_addr = 16'(a); cpu_wdata = 8'(d);
   endtask

   // drive an address with no write and settle past the model compare
   task automatic look(int a);
      @(negedge clk);
      cpu_wr = 1'b0; cpu_addr = 16'(a);
      #2;
   endtask

   task automatic do_reset();
      @(negedge clk);
      cpu_wr = 1'b0; rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_NS * 20000);
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      do_reset();
      // R1 reset state: linear map, no scheme
      look('h0000); chk("R1", int'(scheme), 0); chk("R1", int'(rom_addr), 'h0000);
      look('h5123); chk("R1", int'(rom_addr), 'h5123);
      look('hBFFF); chk("R1", int'(rom_addr), 'hBFFF);

      // R2 zero writes do not select a scheme
      wr('hFFFE, 0); look('h0000); chk("R2", int'(scheme), 0);
      wr('h0000, 0); look('h0000); chk("R2", int'(scheme), 0);

      // R2/R7 slot-16K selected; bank 9 folds to 1
      wr('hFFFF, 9); look('h8010); chk("R2", int'(scheme), 1); chk("R7", int'(rom_addr), 'h4010);
      // R4 slot 0 bank, first 1 KB fixed
      wr('hFFFD, 5);
      look('h0200); chk("R4", int'(rom_addr), 'h0200);
      look('h0400); chk("R4", int'(rom_addr), 'h14400);
      wr('hFFFE, 3); look('h4abc); chk("R4", int'(rom_addr), 'hCABC);

      // R3 other schemes' writes ignored
      wr('h0001, 7); look('h8010); chk("R3", int'(scheme), 1); chk("R3", int'(rom_addr), 'h4010);
      wr('h8000, 6); look('h8010); chk("R3", int'(rom_addr), 'h4010);

      // R5 cartridge RAM in slot 2
      wr('hFFFC, 'h08); look('h8123); chk("R5", int'(cram_sel), 1); chk("R5", int'(cram_bank), 0);
      chk("R6", int'(ctl_anomaly), 0);
      wr('hFFFC, 'h8C); look('hA000); chk("R5", int'(cram_bank), 1); chk("R6", int'(ctl_anomaly), 0);
      // R6 illegal control bits
      wr('hFFFC, 'h01); look('h8010); chk("R6", int'(ctl_anomaly), 1); chk("R5", int'(cram_sel), 0);
      look('h8010); chk("R6", int'(ctl_anomaly), 0);

      // R10 work RAM and mirror
      wr('hE123, 'h55); #2; chk("R10", int'(wram_we), 1); chk("R10", int'(wram_addr), 'h0123);
      look('hC123); chk("R10", int'(wram_sel), 1); chk("R11", int'(rom_addr), 0);

      // R8 window-8K scheme
      do_reset();
      wr('h0002, 'h1F); look('h4010); chk("R8", int'(scheme), 2); chk("R7", int'(rom_addr), 'h1E010);
      look('h6010); chk("R8", int'(rom_addr), 'h6010);
      look('h8010); chk("R8", int'(rom_addr), 'h8010);
      look('h0100); chk("R8", int'(rom_addr), 'h0100);
      wr('h0000, 6); look('h8010); chk("R8", int'(rom_addr), 'hC010);
      wr('h0001, 1); look('hA010); chk("R8", int'(rom_addr), 'h2010);
      wr('hFFFF, 3); look('h8010); chk("R3", int'(scheme), 2); chk("R3", int'(rom_addr), 'hC010);
      wr('h0000, 0); look('h8010); chk("R8", int'(rom_addr), 'h0010);

      // R9 base-16K scheme
      do_reset();
      wr('h0000, 0); look('h0000); chk("R2", int'(scheme), 0);
      wr('h4000, 0); look('h4010); chk("R9", int'(scheme), 3); chk("R9", int'(rom_addr), 'h0010);
      wr('hA000, 5); look('h8010); chk("R9", int'(rom_addr), 'h14010);
      wr('h0000, 7); look('h0100); chk("R9", int'(rom_addr), 'h1C100);
      wr('h0002, 3); look('h0100); chk("R3", int'(rom_addr), 'h1C100);
      wr('hFFFC, 'h08); look('h8010); chk("R3", int'(cram_sel), 0);

      // R2 priority: window-8K beats base-16K at address 0
      do_reset();
      wr('h0000, 3); look('h8010); chk("R2", int'(scheme), 2); chk("R2", int'(rom_addr), 'h6010);

      look('h0000);
      summary();
   end
endmodule